// File: doc/BRIEF.md
# Host FIFO Access Freeze Controller

This block decides when an external host, running on its own clock, may touch a FIFO that it shares with an on-chip CPU. The CPU drives a run/freeze control level. Raising it to run opens the FIFO to the host. Dropping it asks for a freeze. The freeze lands only once any host read or write already on the bus has ended. When the freeze lands, both DMA request lines fall and the host status byte marks the interface as frozen. The CPU-side live flag also drops, which tells the CPU the handover is complete.

While the interface is frozen, any host FIFO access is not served. It is recorded instead as a read-underrun or write-overrun flag in the host status byte. Reading that byte clears these flags. A service request is raised whenever the freeze lands, and whenever an access is refused. This request cannot be masked. It is held pending until the host reads its status, and it reaches the interrupt pin only when the mode register enables that pin.

Hardware reset and a synchronous soft reset both put the block into the frozen state, clear the mode register and raise the service request. The run request from the CPU is then ignored for a settle window of `SETTLE_CYC` clocks.

Top module: `hff_freeze_ctrl`

## Requirements
- R1: Hardware or soft reset gives `host_stat` = 8'h02, clears the mode register (so `dreq_in`, `dreq_out` and `host_irq` are low), and drives `fifo_host_en` and `cpu_xfer_live` low.
- R2: For `SETTLE_CYC` (default 24) clocks after any reset, `cpu_run` has no effect and the block stays frozen.
- R3: When `cpu_run` is 1 after settling, the block enters run mode. `fifo_host_en` and `cpu_xfer_live` go to 1 and `host_stat[1]` goes to 0.
- R4: The mode register is written with `mode_wdata` when `mode_we` is high. Bit 0 enables `host_irq`, bit 1 enables `dreq_in` and bit 2 enables `dreq_out`. In run mode, `dreq_in` = bit1 AND `fifo_in_room`, and `dreq_out` = bit2 AND `fifo_out_avail`.
- R5: If `cpu_run` falls while a synchronised host read or write is active, the block stays unfrozen (`cpu_xfer_live` = 1) until that strobe has ended.
- R6: When the freeze takes effect, `dreq_in` and `dreq_out` are 0, `host_stat[1]` is 1, and `cpu_xfer_live` and `fifo_host_en` are 0.
- R7: While frozen, the start of a host read sets `host_stat[7]` and the start of a host write sets `host_stat[3]`. A pulse on `host_stat_rd` clears both flags.
- R8: If a frozen access starts in the same cycle as a `host_stat_rd` pulse, the new flag stays set and the service request stays pending.
- R9: The service request is set by reset, by the freeze taking effect and by a frozen access, whatever the interrupt enable is. `host_stat_rd` clears it, and `host_irq` = request AND mode bit 0.
- R10: If the host reads its status before the interrupt enable is set, `host_irq` stays low once the enable is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cpu_run | input | 1 | CPU control level: 1 = run, 0 = freeze |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Mode value: [0] irq enable, [1] input DMA enable, [2] output DMA enable |
| host_rd_n | input | 1 | Asynchronous host FIFO read strobe, active low |
| host_wr_n | input | 1 | Asynchronous host FIFO write strobe, active low |
| host_stat_rd | input | 1 | One-clock pulse: host reads its status byte |
| fifo_in_room | input | 1 | FIFO can accept host data |
| fifo_out_avail | input | 1 | FIFO holds data for the host |
| dreq_in | output | 1 | DMA request for host-to-FIFO transfers |
| dreq_out | output | 1 | DMA request for FIFO-to-host transfers |
| host_irq | output | 1 | Host interrupt request |
| host_stat | output | 8 | Host status: [1] frozen, [3] write overrun, [7] read underrun |
| fifo_host_en | output | 1 | Host FIFO access permitted |
| cpu_xfer_live | output | 1 | CPU status: 1 until the freeze is in effect |

## Verification
Two events can meet in one cycle: a status read that clears the access flags, and the synchronised start of a new frozen read that sets them. The bench lowers the read strobe and counts the synchroniser edges so that the `host_stat_rd` pulse covers exactly the edge on which the read start registers. It then expects `host_stat[7]` and `host_irq` to remain high. In a separate step, a status read with no access beside it is shown to clear both.

// File: rtl/hff_pkg.sv
package hff_pkg;
  typedef enum logic [1:0] {
    ST_FROZEN = 2'd0,
    ST_RUN    = 2'd1,
    ST_DRAIN  = 2'd2
  } frz_state_e;

  localparam int STAT_W    = 8;
  localparam int STAT_FRZ  = 1;
  localparam int STAT_WOVR = 3;
  localparam int STAT_RUND = 7;

  localparam int MODE_W    = 3;
  localparam int MODE_IRQ  = 0;
  localparam int MODE_DIN  = 1;
  localparam int MODE_DOUT = 2;

  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic dma_gate(input logic live, input logic en, input logic lvl);
    return live & en & lvl;
  endfunction
endpackage

// File: rtl/hff_sync.sv
module hff_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], async_in[i]};
        prev <= sh[STAGES-1];
      end
    end
    assign lvl[i]  = sh[STAGES-1];
    assign rise[i] = sh[STAGES-1] & ~prev;
  end
endmodule

// File: rtl/hff_seq.sv
module hff_seq
  import hff_pkg::*;
#(
  parameter int SETTLE_CYC = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cpu_run,
  input  logic       xfer_busy,
  output frz_state_e state,
  output logic       freeze_enter,
  output logic       run_enter
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt;
  logic          settled;
  frz_state_e    nxt;

  assign settled = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (soft_rst)   cnt <= '0;
    else if (!settled)   cnt <= cnt + 1'b1;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FROZEN: if (settled && cpu_run) nxt = ST_RUN;
      ST_RUN:    if (!cpu_run) nxt = xfer_busy ? ST_DRAIN : ST_FROZEN;
      ST_DRAIN:  if (!xfer_busy) nxt = ST_FROZEN;
      default:   nxt = ST_FROZEN;
    endcase
    if (soft_rst) nxt = ST_FROZEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FROZEN;
    else        state <= nxt;
  end

  assign freeze_enter = (state != ST_FROZEN) && (nxt == ST_FROZEN);
  assign run_enter    = (state == ST_FROZEN) && (nxt == ST_RUN);

  AST_SETTLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> state == ST_FROZEN); // R2
  AST_NO_CUT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_FROZEN && xfer_busy && !soft_rst) |=> state != ST_FROZEN); // R5
endmodule

// File: rtl/hff_stat.sv
module hff_stat
  import hff_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              frozen,
  input  logic              freeze_enter,
  input  logic              run_enter,
  input  logic              rd_start,
  input  logic              wr_start,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] host_stat,
  output logic              irq_pend
);
  logic frz_b, rund_b, wovr_b;
  logic rd_hit, wr_hit;

  assign rd_hit = frozen & rd_start;
  assign wr_hit = frozen & wr_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_b <= 1'b1; rund_b <= 1'b0; wovr_b <= 1'b0; irq_pend <= 1'b1;
    end else if (soft_rst) begin
      frz_b <= 1'b1; rund_b <= 1'b0; wovr_b <= 1'b0; irq_pend <= 1'b1;
    end else begin
      if (run_enter)         frz_b <= 1'b0;
      else if (freeze_enter) frz_b <= 1'b1;
      rund_b   <= sticky_next(rund_b, rd_hit, stat_rd);
      wovr_b   <= sticky_next(wovr_b, wr_hit, stat_rd);
      irq_pend <= sticky_next(irq_pend, freeze_enter | rd_hit | wr_hit, stat_rd);
    end
  end

  always_comb begin
    host_stat            = '0;
    host_stat[STAT_FRZ]  = frz_b;
    host_stat[STAT_WOVR] = wovr_b;
    host_stat[STAT_RUND] = rund_b;
  end

  AST_RD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !soft_rst) |=> host_stat[STAT_RUND]); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && stat_rd && !soft_rst) |=> host_stat[STAT_WOVR] && irq_pend); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rd_hit && !wr_hit && !freeze_enter && !soft_rst) |=> !irq_pend); // R9
  AST_FRZ_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_enter && !soft_rst) |=> host_stat[STAT_FRZ]); // R6
endmodule

// File: rtl/hff_freeze_ctrl.sv
module hff_freeze_ctrl
  import hff_pkg::*;
#(
  parameter int SETTLE_CYC  = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cpu_run,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_stat_rd,
  input  logic              fifo_in_room,
  input  logic              fifo_out_avail,
  output logic              dreq_in,
  output logic              dreq_out,
  output logic              host_irq,
  output logic [STAT_W-1:0] host_stat,
  output logic              fifo_host_en,
  output logic              cpu_xfer_live
);
  localparam int RD = 0;
  localparam int WR = 1;

  logic [1:0]        strobe_lvl, strobe_rise;
  logic              xfer_busy, freeze_enter, run_enter, irq_pend, live;
  logic [MODE_W-1:0] mode_q;
  frz_state_e        state;

  hff_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({~host_wr_n, ~host_rd_n}),
    .lvl(strobe_lvl), .rise(strobe_rise)
  );

  assign xfer_busy = strobe_lvl[RD] | strobe_lvl[WR];

  hff_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpu_run(cpu_run),
    .xfer_busy(xfer_busy), .state(state),
    .freeze_enter(freeze_enter), .run_enter(run_enter)
  );

  assign live = (state != ST_FROZEN);

  hff_stat u_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frozen(!live),
    .freeze_enter(freeze_enter), .run_enter(run_enter),
    .rd_start(strobe_rise[RD]), .wr_start(strobe_rise[WR]),
    .stat_rd(host_stat_rd), .host_stat(host_stat), .irq_pend(irq_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= '0;
    else if (soft_rst) mode_q <= '0;
    else if (mode_we)  mode_q <= mode_wdata;
  end

  assign dreq_in       = dma_gate(live, mode_q[MODE_DIN], fifo_in_room);
  assign dreq_out      = dma_gate(live, mode_q[MODE_DOUT], fifo_out_avail);
  assign host_irq      = irq_pend & mode_q[MODE_IRQ];
  assign fifo_host_en  = live;
  assign cpu_xfer_live = live;

  AST_DMA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FROZEN) |-> (!dreq_in && !dreq_out)); // R6
  AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !mode_we) |=> (!host_irq && !dreq_in && !dreq_out)); // R1
endmodule

// File: tb/tb_hff_freeze_ctrl.sv
`timescale 1ns/1ps
module tb_hff_freeze_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0, cpu_run = 1'b0, mode_we = 1'b0;
  logic [2:0] mode_wdata = '0;
  logic host_rd_n = 1'b1, host_wr_n = 1'b1, host_stat_rd = 1'b0;
  logic fifo_in_room = 1'b0, fifo_out_avail = 1'b0;
  logic dreq_in, dreq_out, host_irq, fifo_host_en, cpu_xfer_live;
  logic [7:0] host_stat;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hff_freeze_ctrl dut (.*);

  // {mode[2:0], room, avail, exp_dreq_in, exp_dreq_out}
  localparam logic [6:0] DMA_VEC [7] = '{
    7'b110_11_11, 7'b010_11_10, 7'b100_11_01, 7'b110_01_01,
    7'b110_10_10, 7'b000_11_00, 7'b111_00_00 };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [2:0] v);
    mode_wdata = v; mode_we = 1'b1; cyc(1); mode_we = 1'b0;
  endtask

  task automatic stat_read();
    host_stat_rd = 1'b1; cyc(1); host_stat_rd = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cpu_run = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 stat", host_stat, 8'h02);
    chk("R1 outs", {dreq_in, dreq_out, host_irq, fifo_host_en, cpu_xfer_live}, 5'b0);
    // R9 pending from reset reaches pin once enabled, without a status read
    cyc(4);
    wr_mode(3'b001);
    chk("R9 irq after reset", host_irq, 1'b1);
    wr_mode(3'b000);
    // R2 still frozen inside settle window
    chk("R2 settle hold", {fifo_host_en, host_stat[1]}, 2'b01);
    cyc(25);
    chk("R3 run", {fifo_host_en, cpu_xfer_live, host_stat[1]}, 3'b110);
    // R10 read before enable
    stat_read();
    wr_mode(3'b001);
    chk("R10 irq stays low", host_irq, 1'b0);

    // R4 DMA gating table
    for (int i = 0; i < 7; i++) begin
      wr_mode(DMA_VEC[i][6:4]);
      fifo_in_room = DMA_VEC[i][3]; fifo_out_avail = DMA_VEC[i][2];
      #1;
      chk($sformatf("R4 vec%0d", i), {dreq_in, dreq_out}, DMA_VEC[i][1:0]);
      cyc(1);
    end

    // R5 freeze waits for in-flight read
    wr_mode(3'b110);
    fifo_in_room = 1'b1; fifo_out_avail = 1'b1;
    host_rd_n = 1'b0;
    cyc(4);
    cpu_run = 1'b0;
    cyc(5);
    chk("R5 still live", {cpu_xfer_live, host_stat[1], dreq_in, dreq_out}, 4'b1011);
    host_rd_n = 1'b1;
    cyc(5);
    chk("R6 frozen", {cpu_xfer_live, fifo_host_en, host_stat[1], dreq_in, dreq_out}, 5'b00100);
    chk("R7 no flag on drained read", host_stat, 8'h02);
    wr_mode(3'b111);
    chk("R9 irq on freeze", host_irq, 1'b1);
    stat_read();
    chk("R9 read clears irq", host_irq, 1'b0);

    // R7 frozen read and write
    host_rd_n = 1'b0; cyc(3); host_rd_n = 1'b1; cyc(3);
    chk("R7 read underrun", host_stat, 8'h82);
    chk("R9 irq on frozen access", host_irq, 1'b1);
    host_wr_n = 1'b0; cyc(3); host_wr_n = 1'b1; cyc(3);
    chk("R7 write overrun", host_stat, 8'h8A);
    stat_read();
    chk("R7 flags cleared", host_stat, 8'h02);
    chk("R9 irq cleared", host_irq, 1'b0);

    // R8 read start and status read in same cycle
    host_rd_n = 1'b0;
    cyc(2);
    host_stat_rd = 1'b1;
    cyc(1);
    host_stat_rd = 1'b0;
    chk("R8 flag kept", host_stat[7], 1'b1);
    chk("R8 irq kept", host_irq, 1'b1);
    host_rd_n = 1'b1;
    cyc(3);
    stat_read();
    chk("R7 clear after R8", host_stat, 8'h02);

    // soft reset: R1, R2
    cpu_run = 1'b1;
    cyc(3);
    chk("R3 rerun", fifo_host_en, 1'b1);
    wr_mode(3'b110);
    chk("R4 dma live", {dreq_in, dreq_out}, 2'b11);
    soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
    chk("R1 soft stat", host_stat, 8'h02);
    chk("R1 soft outs", {dreq_in, dreq_out, host_irq, fifo_host_en, cpu_xfer_live}, 5'b0);
    cyc(10);
    chk("R2 soft settle hold", fifo_host_en, 1'b0);
    cyc(20);
    chk("R2 soft settle done", {fifo_host_en, host_stat[1]}, 2'b10);

    done = 1;
    summary();
  end
endmodule